// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit linear address into a physical address by reading two levels of translation entries from a word-addressed memory. The first read fetches an entry from a directory whose base comes from a configuration register. That entry points either to a second-level table or, when large pages are enabled, directly to a 4 MB frame. The second read fetches the entry that names a 4 KB frame. Each request carries an access kind (read or write) and a privilege level (user or supervisor). Both levels are checked for presence, reserved bits, write permission and user permission.

A client raises `req_valid` while `req_ready` is high. Some cycles later the block gives a one-cycle response: either a physical address, or a fault flag. On a fault, the linear address is also copied into a held fault-address register. When paging is switched off, the linear address passes straight through and memory is not read. The memory port holds its read request and address until the memory answers with `mem_ready`, so the memory may take any number of cycles.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `rsp_valid` and `mem_rd` are 0, `req_ready` is 1 and `fault_addr` is 0.
- R2: With `cfg_pg_en` low at acceptance, the response is not a fault, `rsp_paddr` equals the request address, and memory is not read.
- R3: The linear address splits into a directory index (bits 31:22), a table index (bits 21:12) and a byte offset (bits 11:0). The first read goes to `{cfg_dir_base[31:12], 12'b0} + 4*directory index`.
- R4: Entry fields: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 7 page size, bits 31:12 base. For a small page, the second read goes to `{dir_entry[31:12], 12'b0} + 4*table index`, and the result is `{tbl_entry[31:12], offset}`.
- R5: A clear present bit in the directory entry gives a fault after one read. A clear present bit in the table entry gives a fault after two reads.
- R6: A write faults when the combined writable bit (AND of the levels used) is 0 and the access is user-mode or `cfg_wp` is 1. A supervisor write with `cfg_wp` at 0 ignores the writable bits.
- R7: A user-mode access faults when the combined user bit (AND of the levels used) is 0. Supervisor accesses ignore the user bits.
- R8: A reserved bit faults. For a table entry this is bit 7. For a large directory entry it is any of bits 21:12.
- R9: With `cfg_large_en` high and bit 7 of the directory entry set, only one read is made and the result is `{dir_entry[31:22], addr[21:0]}`. With `cfg_large_en` low, bit 7 of the directory entry is ignored and the walk continues to the table.
- R10: On every fault, `fault_addr` takes the full linear address of that request. It keeps that value through later responses that do not fault.
- R11: Each accepted request gives exactly one `rsp_valid` pulse of one cycle. `req_ready` is low while a walk is in progress. `mem_rd` and `mem_addr` hold steady until `mem_ready` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user-mode, 0 = supervisor |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 32 | Physical address (meaningful when no fault) |
| fault_addr | output | 32 | Linear address of the most recent fault |
| mem_rd | output | 1 | Entry read request, held until answered |
| mem_addr | output | 32 | Byte address of the entry word |
| mem_ready | input | 1 | Memory returns data this cycle |
| mem_rdata | input | 32 | Entry word read from memory |
| cfg_dir_base | input | 32 | Directory base register (bits 31:12 used) |
| cfg_pg_en | input | 1 | Translation enable |
| cfg_wp | input | 1 | Apply write protection to supervisor writes |
| cfg_large_en | input | 1 | Allow 4 MB pages at the directory level |

## Verification
The assertions assume that `mem_ready` is raised only while `mem_rd` is high. They also assume that the configuration inputs do not change between acceptance and response, because the walker samples them while it works. The bench's memory model raises `mem_ready` only against a pending read, and it drops `mem_ready` before the next request can be seen. The bench changes the configuration only while the walker is idle, after the previous response has arrived. Memory latency is varied from zero to two wait cycles, so the hold-steady properties are exercised.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int PW_ADDR_W   = 32;
  localparam int PW_OFF_W    = 12;
  localparam int PW_IDX_W    = 10;
  localparam int PW_LG_OFF_W = PW_OFF_W + PW_IDX_W;
  localparam int PW_FRAME_W  = PW_ADDR_W - PW_OFF_W;
  localparam int PW_LG_W     = PW_ADDR_W - PW_LG_OFF_W;
  localparam int PW_WORD_LSB = 2;

  localparam int BIT_PRES = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_USR  = 2;
  localparam int BIT_ACC  = 5;
  localparam int BIT_SIZE = 7;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_DIR,
    WK_TBL,
    WK_DONE,
    WK_FAULT
  } wk_state_e;

  function automatic logic [PW_ADDR_W-1:0] entry_addr(
      input logic [PW_FRAME_W-1:0] base,
      input logic [PW_IDX_W-1:0]   idx);
    return {base, idx, {PW_WORD_LSB{1'b0}}};
  endfunction

  function automatic logic [PW_ADDR_W-1:0] small_pa(
      input logic [PW_FRAME_W-1:0] frame,
      input logic [PW_OFF_W-1:0]   off);
    return {frame, off};
  endfunction

  function automatic logic [PW_ADDR_W-1:0] large_pa(
      input logic [PW_LG_W-1:0]    frame,
      input logic [PW_LG_OFF_W-1:0] off);
    return {frame, off};
  endfunction
endpackage

// File: rtl/pgwalk_perm.sv
module pgwalk_perm (
  input  logic ent_p,
  input  logic ent_w,
  input  logic ent_u,
  input  logic up_w,
  input  logic up_u,
  input  logic is_write,
  input  logic is_user,
  input  logic wp,
  output logic not_present,
  output logic wr_viol,
  output logic usr_viol
);
  logic eff_w, eff_u;
  assign eff_w       = up_w & ent_w;
  assign eff_u       = up_u & ent_u;
  assign not_present = ~ent_p;
  assign wr_viol     = is_write & ~eff_w & (is_user | wp);
  assign usr_viol    = is_user & ~eff_u;
endmodule

// File: rtl/pgwalk_fault_reg.sv
module pgwalk_fault_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] addr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (capture) q <= addr;
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PW_ADDR_W-1:0] req_addr,
  input  logic                 req_write,
  input  logic                 req_user,
  output logic                 rsp_valid,
  output logic                 rsp_fault,
  output logic [PW_ADDR_W-1:0] rsp_paddr,
  output logic [PW_ADDR_W-1:0] fault_addr,
  output logic                 mem_rd,
  output logic [PW_ADDR_W-1:0] mem_addr,
  input  logic                 mem_ready,
  input  logic [PW_ADDR_W-1:0] mem_rdata,
  input  logic [PW_ADDR_W-1:0] cfg_dir_base,
  input  logic                 cfg_pg_en,
  input  logic                 cfg_wp,
  input  logic                 cfg_large_en
);
  localparam int DIR_HI = PW_ADDR_W - 1;
  localparam int DIR_LO = PW_LG_OFF_W;
  localparam int TBL_HI = PW_LG_OFF_W - 1;
  localparam int TBL_LO = PW_OFF_W;

  wk_state_e              state_q;
  logic [PW_ADDR_W-1:0]   laddr_q, paddr_q;
  logic                   wr_q, usr_q, pde_w_q, pde_u_q;
  logic [PW_FRAME_W-1:0]  tbl_base_q;

  // named events
  logic accept, dir_hit, tbl_hit, dir_large, dir_rsvd, tbl_rsvd;
  logic dir_fault, tbl_fault, fault_capture;
  logic d_np, d_wv, d_uv, t_np, t_wv, t_uv;
  logic unused_bits;

  assign accept    = (state_q == WK_IDLE) && req_valid;
  assign dir_hit   = (state_q == WK_DIR) && mem_ready;
  assign tbl_hit   = (state_q == WK_TBL) && mem_ready;
  assign dir_large = cfg_large_en & mem_rdata[BIT_SIZE];
  assign dir_rsvd  = dir_large & (|mem_rdata[TBL_HI:TBL_LO]);
  assign tbl_rsvd  = mem_rdata[BIT_SIZE];
  assign unused_bits = ^{cfg_dir_base[PW_OFF_W-1:0], mem_rdata[PW_OFF_W-1:BIT_SIZE+1],
                         mem_rdata[BIT_SIZE-1:BIT_USR+1], mem_rdata[BIT_ACC]};

  // directory level: permissions only matter for a large page
  pgwalk_perm u_dir_perm (
    .ent_p(mem_rdata[BIT_PRES]), .ent_w(mem_rdata[BIT_WR]), .ent_u(mem_rdata[BIT_USR]),
    .up_w(1'b1), .up_u(1'b1), .is_write(wr_q), .is_user(usr_q), .wp(cfg_wp),
    .not_present(d_np), .wr_viol(d_wv), .usr_viol(d_uv)
  );

  // table level: combined with the directory's rights
  pgwalk_perm u_tbl_perm (
    .ent_p(mem_rdata[BIT_PRES]), .ent_w(mem_rdata[BIT_WR]), .ent_u(mem_rdata[BIT_USR]),
    .up_w(pde_w_q), .up_u(pde_u_q), .is_write(wr_q), .is_user(usr_q), .wp(cfg_wp),
    .not_present(t_np), .wr_viol(t_wv), .usr_viol(t_uv)
  );

  assign dir_fault     = d_np | (dir_large & (dir_rsvd | d_wv | d_uv));
  assign tbl_fault     = t_np | tbl_rsvd | t_wv | t_uv;
  assign fault_capture = (dir_hit & dir_fault) | (tbl_hit & tbl_fault);

  pgwalk_fault_reg #(.W(PW_ADDR_W)) u_fault_reg (
    .clk(clk), .rst_n(rst_n), .capture(fault_capture), .addr(laddr_q), .q(fault_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WK_IDLE;
      laddr_q    <= '0;
      paddr_q    <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      pde_w_q    <= 1'b0;
      pde_u_q    <= 1'b0;
      tbl_base_q <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: if (accept) begin
          laddr_q <= req_addr;
          wr_q    <= req_write;
          usr_q   <= req_user;
          if (cfg_pg_en) state_q <= WK_DIR;
          else begin
            paddr_q <= req_addr;
            state_q <= WK_DONE;
          end
        end
        WK_DIR: if (mem_ready) begin
          if (dir_fault) state_q <= WK_FAULT;
          else if (dir_large) begin
            paddr_q <= large_pa(mem_rdata[DIR_HI:DIR_LO], laddr_q[TBL_HI:0]);
            state_q <= WK_DONE;
          end else begin
            tbl_base_q <= mem_rdata[PW_ADDR_W-1:PW_OFF_W];
            pde_w_q    <= mem_rdata[BIT_WR];
            pde_u_q    <= mem_rdata[BIT_USR];
            state_q    <= WK_TBL;
          end
        end
        WK_TBL: if (mem_ready) begin
          if (tbl_fault) state_q <= WK_FAULT;
          else begin
            paddr_q <= small_pa(mem_rdata[PW_ADDR_W-1:PW_OFF_W], laddr_q[PW_OFF_W-1:0]);
            state_q <= WK_DONE;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == WK_IDLE);
  assign mem_rd    = (state_q == WK_DIR) || (state_q == WK_TBL);
  assign mem_addr  = (state_q == WK_DIR)
                   ? entry_addr(cfg_dir_base[PW_ADDR_W-1:PW_OFF_W], laddr_q[DIR_HI:DIR_LO])
                   : entry_addr(tbl_base_q, laddr_q[TBL_HI:TBL_LO]);
  assign rsp_valid = (state_q == WK_DONE) || (state_q == WK_FAULT);
  assign rsp_fault = (state_q == WK_FAULT);
  assign rsp_paddr = paddr_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] rsp_paddr,
  input logic [31:0] fault_addr,
  input logic        mem_rd,
  input logic [31:0] mem_addr,
  input logic        mem_ready,
  input logic [31:0] mem_rdata,
  input logic        cfg_pg_en,
  input logic        dir_hit
);
  logic [31:0] seen_addr;
  logic        seen_pg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_addr <= '0;
      seen_pg   <= 1'b0;
    end else if (req_valid && req_ready) begin
      seen_addr <= req_addr;
      seen_pg   <= cfg_pg_en;
    end
  end

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready);

  // R11
  hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  // R10
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (fault_addr == seen_addr));

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !seen_pg) |-> (!rsp_fault && rsp_paddr == seen_addr));

  // R4
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == seen_addr[11:0]));

  // R5
  dir_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_hit && !mem_rdata[0]) |=> (rsp_valid && rsp_fault));
endmodule

bind pgwalk_top pgwalk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .fault_addr(fault_addr), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
  .cfg_pg_en(cfg_pg_en), .dir_hit(dir_hit)
);

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_fault, mem_rd;
  logic [31:0] rsp_paddr, fault_addr, mem_addr;
  logic mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] cfg_dir_base = 32'h0001_0000;
  logic cfg_pg_en = 1'b0, cfg_wp = 1'b0, cfg_large_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwalk_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .fault_addr(fault_addr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .cfg_dir_base(cfg_dir_base),
    .cfg_pg_en(cfg_pg_en), .cfg_wp(cfg_wp), .cfg_large_en(cfg_large_en)
  );

  typedef struct {
    logic [31:0] pa;
    logic        flt;
    int          nr;
    logic [31:0] fa;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_run = 0, n_fail = 0;
  int reads = 0, wait_cnt = 0, lat = 0;
  logic [31:0] last_fa = '0;
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] la_of(input int d, input int t, input int o);
    return (32'(d) << 22) | (32'(t) << 12) | 32'(o);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model: variable wait, data returned on the negedge before the accepting edge
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end else if (mem_rd) begin
      if (wait_cnt >= lat) begin
        mem_rdata = rd(mem_addr);
        mem_ready = 1'b1;
        reads++;
      end else wait_cnt++;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) chk("R11", "unexpected response", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "fault", 32'(rsp_fault), 32'(e.flt));
        if (!e.flt) chk(e.tag, "paddr", rsp_paddr, e.pa);
        chk(e.tag, "reads", 32'(reads), 32'(e.nr));
        chk("R10", "fault_addr", fault_addr, e.fa);
      end
      reads = 0;
    end
  end

  function automatic logic denied(input logic w, input logic u, input logic wr, input logic us);
    return (us && !u) || (wr && !w && (us || cfg_wp));
  endfunction

  task automatic send(input logic [31:0] la, input logic wr, input logic us, input int lt, input string tag);
    exp_t e;
    logic [31:0] pde, pte;
    e.tag = tag; e.flt = 1'b0; e.pa = '0; e.nr = 0;
    if (!cfg_pg_en) e.pa = la;
    else begin
      pde = rd({cfg_dir_base[31:12], 12'h0} + 32'(la[31:22]) * 4);
      e.nr = 1;
      if (!pde[0]) e.flt = 1'b1;
      else if (cfg_large_en && pde[7]) begin
        if (pde[21:12] != 0 || denied(pde[1], pde[2], wr, us)) e.flt = 1'b1;
        else e.pa = {pde[31:22], la[21:0]};
      end else begin
        pte = rd({pde[31:12], 12'h0} + 32'(la[21:12]) * 4);
        e.nr = 2;
        if (!pte[0] || pte[7] || denied(pde[1] & pte[1], pde[2] & pte[2], wr, us)) e.flt = 1'b1;
        else e.pa = {pte[31:12], la[11:0]};
      end
    end
    if (e.flt) last_fa = la;
    e.fa = last_fa;
    lat = lt;
    sb.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = la; req_write = wr; req_user = us; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    // directory at 0x0001_0000
    mem[32'h0001_0004] = 32'h0002_0007;   // idx1: table 0x20000, P W U
    mem[32'h0001_0008] = 32'h0000_0000;   // idx2: absent
    mem[32'h0001_000C] = 32'h0003_0001;   // idx3: table 0x30000, P only
    mem[32'h0001_0010] = 32'h0C00_0087;   // idx4: large, P W U PS
    mem[32'h0001_0014] = 32'h0C40_1083;   // idx5: large with reserved bit 12
    mem[32'h0002_0000] = 32'h00AB_C007;
    mem[32'h0002_0004] = 32'h0000_0000;
    mem[32'h0002_0008] = 32'h00DE_F005;   // P U, read-only
    mem[32'h0002_000C] = 32'h0012_3087;   // reserved bit 7
    mem[32'h0002_0010] = 32'h0045_6003;   // P W, supervisor only
    mem[32'h0003_0000] = 32'h0077_7007;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "mem_rd", 32'(mem_rd), 32'd0);
    chk("R1", "fault_addr", fault_addr, 32'd0);

    send(32'h1234_5678, 1'b1, 1'b1, 0, "R2");          // R2 pass-through
    cfg_pg_en = 1'b1;
    send(la_of(1, 0, 12'h345), 1'b0, 1'b1, 0, "R3");   // R3 R4 small walk
    send(la_of(1, 0, 12'hFFC), 1'b1, 1'b1, 2, "R4");
    send(la_of(2, 7, 12'h010), 1'b0, 1'b0, 1, "R5");   // R5 directory absent
    send(la_of(1, 1, 12'h020), 1'b0, 1'b0, 0, "R5");   // R5 table absent
    send(la_of(1, 2, 12'h030), 1'b1, 1'b1, 1, "R6");   // user write read-only
    send(la_of(1, 2, 12'h040), 1'b1, 1'b0, 0, "R6");   // supervisor write, wp off
    cfg_wp = 1'b1;
    send(la_of(1, 2, 12'h050), 1'b1, 1'b0, 2, "R6");   // supervisor write, wp on
    send(la_of(3, 0, 12'h060), 1'b1, 1'b0, 0, "R6");   // directory not writable
    send(la_of(1, 4, 12'h070), 1'b0, 1'b1, 0, "R7");   // user on supervisor page
    send(la_of(1, 4, 12'h080), 1'b0, 1'b0, 1, "R7");   // supervisor read ok
    send(la_of(3, 0, 12'h090), 1'b0, 1'b1, 0, "R7");   // directory not user
    send(la_of(1, 3, 12'h0A0), 1'b0, 1'b0, 0, "R8");   // table reserved
    cfg_large_en = 1'b1;
    send(la_of(4, 9, 12'h0B0), 1'b1, 1'b1, 1, "R9");   // large page
    send(la_of(5, 0, 12'h0C0), 1'b0, 1'b0, 0, "R8");   // large reserved
    cfg_large_en = 1'b0;
    send(la_of(4, 9, 12'h0D0), 1'b0, 1'b0, 0, "R9");   // size bit ignored
    cfg_pg_en = 1'b0;
    send(32'hFEDC_BA98, 1'b0, 1'b1, 1, "R2");
    summary();
  end
endmodule